// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between the lanes of a 32-wide warp and the memory request port. It takes one memory instruction at a time. The instruction carries a per-lane active mask, one byte address per lane, an access size and a read/write flag. The block then issues the smallest set of aligned transactions that covers every active lane, one transaction per cycle under a ready/valid handshake. Lanes whose addresses fall in the same 128-byte line share one transaction, so any number of lanes that read one address cost a single fetch.

For a store, every transaction carries a full-line byte-enable vector and data vector. Where several lanes write the same byte, the highest-numbered active lane supplies the value. For a load, the memory side returns the whole 128-byte line, tagged with its line index. The block then hands each still-pending lane whose address lies in that line its bytes on the load outputs, in the same cycle.

The control is a three-state machine. **IDLE** accepts an instruction. **ISSUE** presents one transaction per cycle. **DRAIN** waits for outstanding load lines. The transitions are:
- IDLE→ISSUE when an instruction with a non-empty mask is accepted.
- IDLE→IDLE when the accepted mask is empty.
- ISSUE→IDLE on the last handoff of a store, or on the last handoff of a load whose lanes have all been served.
- ISSUE→DRAIN on the last handoff of a load with lanes still pending.
- DRAIN→IDLE when the last pending lane is served.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `in_ready` is 1, `req_valid` is 0 and `ld_valid` is 0.
- R2: `in_ready` is 1 only in IDLE, and never together with `req_valid`. A store instruction finishes at the handoff of its last transaction. A load instruction finishes when its last pending lane is served. Only then is the next instruction accepted.
- R3: Each transaction serves, as `req_lanes`, every remaining active lane whose address lies in one 128-byte line (address bits above bit 6 equal). A lane appears in exactly one transaction of an instruction, and an inactive lane appears in none.
- R4: The transactions of one instruction are issued in strictly ascending `req_addr` order.
- R5: `req_size` is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. It is the smallest size whose block, aligned to that size, covers all bytes the served lanes touch. `req_addr` is the start of that aligned block.
- R6: `req_be` bit k is set when some served lane touches byte k of the 128-byte line. For a store, `req_wdata[8k+7:8k]` holds the byte written there. For a load, `req_wdata` is zero.
- R7: When several served store lanes write the same byte, the value comes from the highest-numbered of them.
- R8: A response carries a line index on `rsp_line` and the line on `rsp_data` (byte k at bits 8k+7:8k). In that cycle, `ld_mask` flags every pending load lane of that line, and `ld_valid` is high. Lane i's bytes appear little-endian at `ld_data[32i+31:32i]`, zero-extended. Each lane is served once.
- R9: An instruction with an all-zero mask is accepted, issues no transaction, and leaves `in_ready` at 1.
- R10: While `req_valid` is 1 and `req_ready` is 0, the transaction fields hold steady.
- R11: 32 lanes reading consecutive 4-byte words from a 128-byte-aligned base give exactly one 128-byte transaction.
- R12: `in_size` codes 0, 1 and 2 select 1-, 2- and 4-byte lane accesses, each lane address aligned to its size. Lane i's store data is `in_wdata[32i+31:32i]`, least significant byte first, and lane i's address is `in_addr[32i+31:32i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_write | input | 1 | 1 store, 0 load |
| in_size | input | 2 | Lane access size code |
| in_mask | input | LANES | Active lanes |
| in_addr | input | LANES*AW | Per-lane byte addresses |
| in_wdata | input | LANES*32 | Per-lane store data |
| req_valid | output | 1 | Transaction presented |
| req_ready | input | 1 | Memory side takes the transaction |
| req_write | output | 1 | Transaction is a store |
| req_addr | output | AW | Aligned start address |
| req_size | output | 2 | Transaction size code |
| req_lanes | output | LANES | Lanes served by the transaction |
| req_be | output | 128 | Touched bytes of the line |
| req_wdata | output | 1024 | Line-positioned store data |
| rsp_valid | input | 1 | Load line returned |
| rsp_line | input | AW-7 | Index of the returned line |
| rsp_data | input | 1024 | Returned line bytes |
| ld_valid | output | 1 | Some lanes served this cycle |
| ld_mask | output | LANES | Lanes served this cycle |
| ld_data | output | LANES*32 | Per-lane load data |

## Verification
The hardest situation to reach is a load line coming back while later lines of the same instruction are still being presented under back-pressure. In that case, pending-lane clearing, the ISSUE-to-DRAIN decision and the held transaction fields all interact. The bench responder answers each load handoff one cycle later, and a periodic `req_ready` stall pattern is applied to half of the runs. Together these put responses in the middle of stalled issue sequences. Stride, size and mask sweeps also make lanes in the same byte collide, which exercises the highest-lane rule.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int LINE_BYTES = 128;
    localparam int LINE_OFS   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } coal_state_t;

    typedef enum logic [1:0] {
        TX_32  = 2'd0,
        TX_64  = 2'd1,
        TX_128 = 2'd2
    } tx_size_t;

    function automatic logic [3:0] lane_nbytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/coal_line_pick.sv
// Chooses the lowest line still owed a transaction, the lanes inside it
// and the 32-byte segments holding the lowest and highest touched byte.
module coal_line_pick
    import coal_pkg::*;
#(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0]       addr,
    input  logic [1:0]                size,
    input  logic [LANES-1:0]          rem,
    output logic [AW-LINE_OFS-1:0]    line,
    output logic [LANES-1:0]          hit,
    output logic [1:0]                lo_seg,
    output logic [1:0]                hi_seg
);
    localparam int LIW = AW - LINE_OFS;

    always_comb begin
        logic             found;
        logic [LIW-1:0]   best;
        logic [6:0]       lo;
        logic [6:0]       hi;
        logic [6:0]       o;
        logic [6:0]       e;
        logic [3:0]       nb;
        found = 1'b0;
        best  = '0;
        o     = '0;
        e     = '0;
        nb    = lane_nbytes(size);
        for (int i = 0; i < LANES; i++) begin
            if (rem[i] && (!found || addr[i*AW+LINE_OFS +: LIW] < best)) begin
                best  = addr[i*AW+LINE_OFS +: LIW];
                found = 1'b1;
            end
        end
        lo  = 7'h7f;
        hi  = 7'h00;
        hit = '0;
        for (int i = 0; i < LANES; i++) begin
            if (rem[i] && addr[i*AW+LINE_OFS +: LIW] == best) begin
                hit[i] = 1'b1;
                o = addr[i*AW +: LINE_OFS];
                e = o + 7'(nb) - 7'd1;
                if (o < lo) lo = o;
                if (e > hi) hi = e;
            end
        end
        line   = best;
        lo_seg = lo[6:5];
        hi_seg = hi[6:5];
    end
endmodule

// File: rtl/coal_txn_shape.sv
// Smallest self-aligned block (32/64/128 bytes) covering the touched span.
module coal_txn_shape
    import coal_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-LINE_OFS-1:0] line,
    input  logic [1:0]             lo_seg,
    input  logic [1:0]             hi_seg,
    output logic [AW-1:0]          base,
    output tx_size_t               size
);
    always_comb begin
        if (lo_seg == hi_seg) begin
            size = TX_32;
            base = {line, lo_seg, 5'b0};
        end else if (lo_seg[1] == hi_seg[1]) begin
            size = TX_64;
            base = {line, lo_seg[1], 6'b0};
        end else begin
            size = TX_128;
            base = {line, 7'b0};
        end
    end
endmodule

// File: rtl/coal_store_merge.sv
// Places lane bytes into a line image; lanes are visited in ascending
// order so a higher lane overwrites a lower one on a shared byte.
module coal_store_merge
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int LANE_BYTES = 4
) (
    input  logic [LANES*LINE_OFS-1:0]     ofs,
    input  logic [LANES*LANE_BYTES*8-1:0] wdata,
    input  logic [LANES-1:0]              hit,
    input  logic [1:0]                    size,
    output logic [LINE_BYTES-1:0]         be,
    output logic [LINE_BYTES*8-1:0]       data
);
    always_comb begin
        logic [6:0] pos;
        logic [3:0] nb;
        be   = '0;
        data = '0;
        pos  = '0;
        nb   = lane_nbytes(size);
        for (int i = 0; i < LANES; i++) begin
            for (int b = 0; b < LANE_BYTES; b++) begin
                if (hit[i] && 4'(b) < nb) begin
                    pos = ofs[i*LINE_OFS +: LINE_OFS] + 7'(b);
                    be[pos] = 1'b1;
                    data[{pos, 3'b000} +: 8] = wdata[(i*LANE_BYTES+b)*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/coal_load_scatter.sv
// Delivers a returned line to every pending lane addressing it.
module coal_load_scatter
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int AW         = 32,
    parameter int LANE_BYTES = 4
) (
    input  logic                          rsp_valid,
    input  logic [AW-LINE_OFS-1:0]        rsp_line,
    input  logic [LINE_BYTES*8-1:0]       rsp_data,
    input  logic [LANES*AW-1:0]           addr,
    input  logic [1:0]                    size,
    input  logic [LANES-1:0]              pend,
    output logic [LANES-1:0]              ld_mask,
    output logic [LANES*LANE_BYTES*8-1:0] ld_data
);
    localparam int LIW    = AW - LINE_OFS;
    localparam int LANE_W = LANE_BYTES * 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic              m;
        logic [LANE_W-1:0] d;
        always_comb begin
            logic [6:0] pos;
            logic [3:0] nb;
            nb  = lane_nbytes(size);
            pos = '0;
            d   = '0;
            m   = rsp_valid && pend[g] && (addr[g*AW+LINE_OFS +: LIW] == rsp_line);
            for (int b = 0; b < LANE_BYTES; b++) begin
                pos = addr[g*AW +: LINE_OFS] + 7'(b);
                if (m && 4'(b) < nb) d[b*8 +: 8] = rsp_data[{pos, 3'b000} +: 8];
            end
        end
        assign ld_mask[g]               = m;
        assign ld_data[g*LANE_W +: LANE_W] = d;
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int AW         = 32,
    parameter int LANE_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic                          in_write,
    input  logic [1:0]                    in_size,
    input  logic [LANES-1:0]              in_mask,
    input  logic [LANES*AW-1:0]           in_addr,
    input  logic [LANES*LANE_BYTES*8-1:0] in_wdata,
    output logic                          req_valid,
    input  logic                          req_ready,
    output logic                          req_write,
    output logic [AW-1:0]                 req_addr,
    output logic [1:0]                    req_size,
    output logic [LANES-1:0]              req_lanes,
    output logic [LINE_BYTES-1:0]         req_be,
    output logic [LINE_BYTES*8-1:0]       req_wdata,
    input  logic                          rsp_valid,
    input  logic [AW-LINE_OFS-1:0]        rsp_line,
    input  logic [LINE_BYTES*8-1:0]       rsp_data,
    output logic                          ld_valid,
    output logic [LANES-1:0]              ld_mask,
    output logic [LANES*LANE_BYTES*8-1:0] ld_data
);
    localparam int         LIW    = AW - LINE_OFS;
    localparam int         LANE_W = LANE_BYTES * 8;
    localparam logic [1:0] SZ_MAX = 2'($clog2(LANE_BYTES));

    coal_state_t                  state, st_n;
    logic [LANES-1:0]             rem, pend, pend_n;
    logic [LANES*AW-1:0]          addr_q;
    logic [LANES*LANE_W-1:0]      wdata_q;
    logic [1:0]                   size_q, size_in;
    logic                         write_q;
    logic [LANES-1:0]             hit;
    logic [LIW-1:0]               line;
    logic [1:0]                   lo_seg, hi_seg;
    logic [AW-1:0]                txn_base;
    tx_size_t                     txn_size;
    logic [LINE_BYTES-1:0]        mbe;
    logic [LINE_BYTES*8-1:0]      mdata;
    logic [LANES*LINE_OFS-1:0]    lane_ofs;
    logic                         accept, fire, last;

    for (genvar g = 0; g < LANES; g++) begin : g_ofs
        assign lane_ofs[g*LINE_OFS +: LINE_OFS] = addr_q[g*AW +: LINE_OFS];
    end

    coal_line_pick #(.LANES(LANES), .AW(AW)) u_pick (
        .addr(addr_q), .size(size_q), .rem(rem),
        .line(line), .hit(hit), .lo_seg(lo_seg), .hi_seg(hi_seg)
    );

    coal_txn_shape #(.AW(AW)) u_shape (
        .line(line), .lo_seg(lo_seg), .hi_seg(hi_seg),
        .base(txn_base), .size(txn_size)
    );

    coal_store_merge #(.LANES(LANES), .LANE_BYTES(LANE_BYTES)) u_merge (
        .ofs(lane_ofs), .wdata(wdata_q), .hit(hit), .size(size_q),
        .be(mbe), .data(mdata)
    );

    coal_load_scatter #(.LANES(LANES), .AW(AW), .LANE_BYTES(LANE_BYTES)) u_scatter (
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_data(rsp_data),
        .addr(addr_q), .size(size_q), .pend(pend),
        .ld_mask(ld_mask), .ld_data(ld_data)
    );

    assign size_in = (in_size > SZ_MAX) ? SZ_MAX : in_size;
    assign accept  = (state == ST_IDLE) && in_valid;
    assign fire    = (state == ST_ISSUE) && req_ready;
    assign last    = (rem & ~hit) == '0;
    assign pend_n  = pend & ~ld_mask;

    // next state
    always_comb begin
        st_n = state;
        unique case (state)
            ST_IDLE:  if (in_valid && in_mask != '0) st_n = ST_ISSUE;
            ST_ISSUE: if (fire && last) st_n = (write_q || pend_n == '0) ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (pend_n == '0) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    // instruction and progress registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            pend    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            rem     <= in_mask;
            pend    <= in_write ? '0 : in_mask;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            size_q  <= size_in;
            write_q <= in_write;
        end else begin
            if (fire) rem <= rem & ~hit;
            pend <= pend_n;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        req_valid = (state == ST_ISSUE);
        req_write = write_q;
        req_addr  = txn_base;
        req_size  = txn_size;
        req_lanes = hit;
        req_be    = mbe;
        req_wdata = write_q ? mdata : '0;
        ld_valid  = |ld_mask;
    end
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LANES-1:0] in_mask,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-1:0]    req_addr,
    input logic [1:0]       req_size,
    input logic [LANES-1:0] req_lanes,
    input logic [127:0]     req_be
);
    logic [AW-1:0]    last_addr;
    logic             have_last;
    logic [LANES-1:0] seen;
    logic [6:0]       amask;

    always_comb begin
        case (req_size)
            2'd0:    amask = 7'h1f;
            2'd1:    amask = 7'h3f;
            default: amask = 7'h7f;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            have_last <= 1'b0;
            seen      <= '0;
        end else if (in_valid && in_ready) begin
            have_last <= 1'b0;
            seen      <= '0;
        end else if (req_valid && req_ready) begin
            have_last <= 1'b1;
            last_addr <= req_addr;
            seen      <= seen | req_lanes;
        end
    end

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && req_valid));
    a_r3_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_lanes != '0);
    a_r3_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_lanes & seen) == '0);
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && have_last) |-> req_addr > last_addr);
    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_addr[6:0] & amask) == 7'd0 && req_size != 2'd3));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_size)
                                       && $stable(req_lanes) && $stable(req_be)));
    a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mask == '0) |=> in_ready);
endmodule

bind warp_coalescer warp_coalescer_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_lanes(req_lanes),
    .req_be(req_be)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_write = 1'b0;
    logic [1:0]    in_size = '0;
    logic [31:0]   in_mask = '0;
    logic [1023:0] in_addr = '0, in_wdata = '0;
    logic          in_ready, req_valid, req_write, ld_valid;
    logic          req_ready = 1'b1;
    logic [31:0]   req_addr, req_lanes, ld_mask;
    logic [1:0]    req_size;
    logic [127:0]  req_be;
    logic [1023:0] req_wdata, ld_data;
    logic          rsp_valid = 1'b0;
    logic [24:0]   rsp_line = '0;
    logic [1023:0] rsp_data = '0;

    always #10 clk = ~clk;

    warp_coalescer u_dut (.*);

    int tests = 0, fails = 0;
    bit stall = 0;
    int cyc = 0;

    logic [31:0] t_addr [32];
    logic [31:0] t_data [32];

    int            e_n, c_n;
    logic [31:0]   e_addr [64], c_addr [64], e_lanes [64], c_lanes [64];
    logic [1:0]    e_size [64], c_size [64];
    logic [127:0]  e_be [64], c_be [64];
    logic [1023:0] e_data [64], c_data [64];
    logic          c_wr [64];
    int            g_cnt [32];
    logic [31:0]   g_data [32];
    logic [24:0]   q_line [64];
    int            q_head = 0, q_tail = 0;

    function automatic logic [7:0] mf(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5a;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [1023:0] act, input logic [1023:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // responder and ready pattern
    always @(negedge clk) begin
        cyc++;
        req_ready <= !(stall && (cyc % 3 == 0));
        if (q_head != q_tail) begin
            rsp_valid <= 1'b1;
            rsp_line  <= q_line[q_head % 64];
            for (int k = 0; k < 128; k++) rsp_data[k*8 +: 8] <= mf({q_line[q_head % 64], 7'(k)});
            q_head++;
        end else begin
            rsp_valid <= 1'b0;
        end
    end

    // monitor, samples mid-cycle
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (req_valid && req_ready && c_n < 64) begin
                c_addr[c_n] = req_addr; c_size[c_n] = req_size; c_lanes[c_n] = req_lanes;
                c_be[c_n] = req_be; c_data[c_n] = req_wdata; c_wr[c_n] = req_write;
                c_n++;
                if (!req_write) begin q_line[q_tail % 64] = req_addr[31:7]; q_tail++; end
            end
            if (ld_valid) begin
                for (int i = 0; i < 32; i++) if (ld_mask[i]) begin
                    g_cnt[i]++; g_data[i] = ld_data[i*32 +: 32];
                end
            end
        end
    end

    task automatic build_exp(input bit wr, input logic [1:0] sz, input logic [31:0] mask);
        logic [31:0] rem;
        logic [24:0] best;
        bit found;
        int nb, lo, hi, o;
        nb = 1 << sz;
        rem = mask;
        e_n = 0;
        while (rem != 0) begin
            found = 0; best = '0;
            for (int i = 0; i < 32; i++)
                if (rem[i] && (!found || t_addr[i][31:7] < best)) begin best = t_addr[i][31:7]; found = 1; end
            e_lanes[e_n] = '0; e_be[e_n] = '0; e_data[e_n] = '0;
            for (int i = 0; i < 32; i++) if (rem[i] && t_addr[i][31:7] == best) begin
                e_lanes[e_n][i] = 1'b1;
                for (int b = 0; b < nb; b++) begin
                    o = int'(t_addr[i][6:0]) + b;
                    e_be[e_n][o] = 1'b1;
                    if (wr) e_data[e_n][o*8 +: 8] = t_data[i][b*8 +: 8];
                end
            end
            lo = 127; hi = 0;
            for (int k = 0; k < 128; k++) if (e_be[e_n][k]) begin
                if (k < lo) lo = k;
                if (k > hi) hi = k;
            end
            if (lo / 32 == hi / 32)      begin e_size[e_n] = 2'd0; e_addr[e_n] = {best, 7'd0} + 32'(lo / 32 * 32); end
            else if (lo / 64 == hi / 64) begin e_size[e_n] = 2'd1; e_addr[e_n] = {best, 7'd0} + 32'(lo / 64 * 64); end
            else                         begin e_size[e_n] = 2'd2; e_addr[e_n] = {best, 7'd0}; end
            rem = rem & ~e_lanes[e_n];
            e_n++;
        end
    endtask

    task automatic run(input bit wr, input logic [1:0] sz, input logic [31:0] mask,
                       input string tag_n, input string tag_d);
        int guard;
        int nb;
        logic [31:0] ev;
        nb = 1 << sz;
        build_exp(wr, sz, mask);
        c_n = 0;
        for (int i = 0; i < 32; i++) begin g_cnt[i] = 0; g_data[i] = '0; end
        @(negedge clk);
        in_valid = 1'b1; in_write = wr; in_size = sz; in_mask = mask;
        for (int i = 0; i < 32; i++) begin in_addr[i*32 +: 32] = t_addr[i]; in_wdata[i*32 +: 32] = t_data[i]; end
        #5;
        guard = 0;
        while (!in_ready && guard < 100) begin @(negedge clk); #5; guard++; end
        @(negedge clk);
        in_valid = 1'b0;
        #5;
        if (mask != 0) check(!in_ready, "R2", "in_ready low while busy", 1024'(in_ready), 1024'(0));
        guard = 0;
        while (!in_ready && guard < 3000) begin @(negedge clk); #5; guard++; end
        @(negedge clk); #5;
        check(in_ready, "R2", "returns to idle", 1024'(in_ready), 1024'(1));
        check(c_n == e_n, tag_n, "transaction count", 1024'(c_n), 1024'(e_n));
        for (int t = 0; t < e_n && t < c_n; t++) begin
            check(c_addr[t] == e_addr[t], "R4", "address/order", 1024'(c_addr[t]), 1024'(e_addr[t]));
            check(c_size[t] == e_size[t], "R5", "size", 1024'(c_size[t]), 1024'(e_size[t]));
            check(c_lanes[t] == e_lanes[t], "R3", "lanes", 1024'(c_lanes[t]), 1024'(e_lanes[t]));
            check(c_be[t] == e_be[t] && c_wr[t] == wr, "R6", "byte enables", 1024'(c_be[t]), 1024'(e_be[t]));
            check(c_data[t] == e_data[t], tag_d, "store data", c_data[t], e_data[t]);
        end
        for (int i = 0; i < 32; i++) begin
            if (!wr && mask[i]) begin
                ev = '0;
                for (int b = 0; b < nb; b++) ev[b*8 +: 8] = mf(t_addr[i] + 32'(b));
                check(g_cnt[i] == 1 && g_data[i] == ev, "R8/R12", $sformatf("lane %0d load", i),
                      1024'({g_cnt[i], g_data[i]}), 1024'({32'd1, ev}));
            end else begin
                check(g_cnt[i] == 0, "R8", $sformatf("lane %0d not served", i), 1024'(g_cnt[i]), 1024'(0));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int strides [7] = '{0, 1, 2, 3, 5, 8, 33};
        logic [31:0] masks [3] = '{32'hffff_ffff, 32'h5555_5555, 32'h8000_0001};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(in_ready && !req_valid && !ld_valid, "R1", "reset state",
              1024'({in_ready, req_valid, ld_valid}), 1024'(3'b100));

        // R11: consecutive words from an aligned base
        for (int i = 0; i < 32; i++) begin t_addr[i] = 32'h1000 + 32'(i*4); t_data[i] = 32'(i); end
        run(0, 2'd2, 32'hffff_ffff, "R11", "R6");

        // R3: broadcast of one address
        for (int i = 0; i < 32; i++) t_addr[i] = 32'h2044;
        run(0, 2'd2, 32'hffff_ffff, "R3", "R6");

        // R9: empty mask
        run(0, 2'd2, 32'h0, "R9", "R6");
        run(1, 2'd2, 32'h0, "R9", "R6");

        // R7: same-address stores, highest lane wins
        for (int i = 0; i < 32; i++) begin t_addr[i] = 32'h3010; t_data[i] = 32'hA000_0000 + 32'(i); end
        run(1, 2'd2, 32'hffff_ffff, "R3", "R7");
        run(1, 2'd2, 32'h7fff_fffe, "R3", "R7");
        for (int i = 0; i < 32; i++) begin t_addr[i] = 32'h3100 + 32'(i % 8); t_data[i] = 32'(i * 17 + 1); end
        run(1, 2'd0, 32'hffff_ffff, "R3", "R7");

        // R4: descending addresses
        for (int i = 0; i < 32; i++) t_addr[i] = 32'h9000 + 32'((31 - i) * 128);
        run(0, 2'd2, 32'hffff_ffff, "R4", "R6");

        // R5 R10 R12: sweep sizes, strides, masks, both directions, with and without stalls
        for (int st = 0; st < 2; st++) begin
            stall = (st == 1);
            for (int sz = 0; sz < 3; sz++)
                for (int s = 0; s < 7; s++)
                    for (int m = 0; m < 3; m++)
                        for (int wr = 0; wr < 2; wr++) begin
                            for (int i = 0; i < 32; i++) begin
                                t_addr[i] = 32'h4_0000 + 32'(st * 8192) + 32'(i * strides[s] * (1 << sz));
                                t_data[i] = 32'h1357_9bdf ^ 32'(i * 32'h0101_0101);
                            end
                            run(wr[0], 2'(sz), masks[m], stall ? "R10" : "R5", "R7");
                        end
        end
        stall = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule